// File: doc/BRIEF.md
# Four-Wire Full-Duplex Serial Slave Port

This block is a byte-level slave for a four-wire serial host link made of a serial clock, an active-low select, a data-in line and a push-pull data-out line. While the host holds select low, the block shifts one byte in and one byte out at the same time, most significant bit first. The received byte reaches the core logic on a single-cycle valid strobe when select returns high. The outgoing byte comes from a parallel transmit input, which is captured at the moment select falls.

All serial pins are sampled in the system clock domain through synchronizer stages, and their edges are detected there. The system clock must run at least eight times faster than the serial clock. Bursts with fewer than eight clocks deliver their bits right-aligned. Bursts with more than eight clocks keep the last eight bits received. Once all eight transmit bits have gone out, the data-out line replays the incoming bits, starting with the first bit received, for as long as select stays low.

Top module: `quad_wire_slave`

## Requirements
- R1: After reset, `sdo_o` is 0, `rx_valid_o` is 0 and `rx_byte_o` is 0x00.
- R2: While selected, `sdi_i` is sampled on each rising edge of `sck_i`, and the first sampled bit becomes bit 7. A burst of exactly 8 clocks delivers the 8 bits in the order they arrived.
- R3: On the falling edge of `sel_n_i`, `tx_byte_i` is captured, and its bit 7 appears on `sdo_o` before any `sck_i` edge. Changes to `tx_byte_i` later in the same burst do not affect `sdo_o`.
- R4: Each falling edge of `sck_i` while selected advances `sdo_o` to the next lower bit of the captured byte. `sdo_o` does not change at any other time, apart from the select falling edge.
- R5: From the 8th falling edge of `sck_i` on, `sdo_o` replays the bits received on `sdi_i`, with the first-received bit first. Bit k of the replay is the bit sampled on rising edge k+1.
- R6: A burst of n < 8 clocks (n ≥ 1) delivers the n received bits in `rx_byte_o[n-1:0]`, with the upper bits 0.
- R7: A burst of more than 8 clocks delivers the last 8 bits received, with the most recent bit in bit 0.
- R8: When `sel_n_i` rises after a burst of at least one clock, `rx_valid_o` pulses high for exactly one cycle. `rx_byte_o` changes only together with that pulse. A burst of zero clocks produces no pulse.
- R9: `sck_i` and `sdi_i` activity while `sel_n_i` is high has no effect on `sdo_o`, `rx_byte_o` or `rx_valid_o`.
- R10: A rising edge of `sck_i` that is seen in the same synchronized sample as the rising edge of `sel_n_i` is still counted into the delivered byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from the host (asynchronous) |
| sel_n_i | input | 1 | Active-low select from the host (asynchronous) |
| sdi_i | input | 1 | Serial data in from the host |
| sdo_o | output | 1 | Serial data out to the host, push-pull |
| tx_byte_i | input | DATA_W | Parallel byte to transmit, captured at select fall |
| rx_byte_o | output | DATA_W | Last byte delivered to the core |
| rx_valid_o | output | 1 | Single-cycle strobe marking a new `rx_byte_o` |

## Verification
The delivery of a byte on a select rise and the capture of a data bit on a serial clock rise can fall into the same system clock cycle. The bench provokes this by raising the serial clock and the select line at the same instant on the eighth bit of a burst, so both edges pass through the synchronizers together. The result is judged by checking that the delivered byte contains that final bit and that exactly one valid pulse follows. The other shared case is the select fall against a serial clock edge, which the synchronization order settles in favour of loading the transmit byte.

// File: rtl/qws_pkg.sv
`timescale 1ns/1ps
package qws_pkg;
    // Positions of the serial pins inside the synchronizer vector
    localparam int unsigned SIG_SCK = 0;
    localparam int unsigned SIG_SEL = 1;
    localparam int unsigned SIG_SDI = 2;
    localparam int unsigned NUM_SIG = 3;

    // Idle levels used as reset values: clock low, select high, data low
    localparam logic [NUM_SIG-1:0] SIG_IDLE = 3'b010;

    function automatic int unsigned count_width(input int unsigned limit);
        return $clog2(limit + 1);
    endfunction
endpackage

// File: rtl/qws_edge_sync.sv
`timescale 1ns/1ps
module qws_edge_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] lvl_o,
    output logic [WIDTH-1:0] prev_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] pipe;
        logic [WIDTH-1:0]             last;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.pipe[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d.pipe[s] = st_q.pipe[s-1];
        end
        st_d.last = st_q.pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                st_q.pipe[s] <= RESET_VAL;
            end
            st_q.last <= RESET_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_o  = st_q.pipe[STAGES-1];
    assign prev_o = st_q.last;

    for (genvar b = 0; b < WIDTH; b++) begin : g_edge
        assign rise_o[b] =  lvl_o[b] & ~prev_o[b];
        assign fall_o[b] = ~lvl_o[b] &  prev_o[b];
    end
endmodule

// File: rtl/qws_shift_core.sv
`timescale 1ns/1ps
module qws_shift_core #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_rise_i,
    input  logic              sck_fall_i,
    input  logic              sel_fall_i,
    input  logic              sel_rise_i,
    input  logic              sel_prev_i,
    input  logic              sdi_i,
    input  logic [DATA_W-1:0] tx_byte_i,
    output logic              sdo_o,
    output logic [DATA_W-1:0] rx_byte_o,
    output logic              rx_valid_o
);
    localparam int unsigned CNT_W = qws_pkg::count_width(DATA_W);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DATA_W);

    typedef struct packed {
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rx;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] out;
        logic              vld;
    } core_t;

    core_t             st_d, st_q;
    logic              active;
    logic [DATA_W-1:0] rx_nxt;
    logic [CNT_W-1:0]  cnt_nxt;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        // the select was low in the previous sample: the window is open,
        // which includes the cycle in which its rise is detected
        active   = ~sel_prev_i;
        rx_nxt   = st_q.rx;
        cnt_nxt  = st_q.cnt;

        if (active && sck_rise_i) begin
            rx_nxt = {st_q.rx[DATA_W-2:0], sdi_i};
            if (st_q.cnt != CNT_MAX) begin
                cnt_nxt = st_q.cnt + CNT_W'(1);
            end
        end

        if (sel_fall_i) begin
            st_d.tx  = tx_byte_i;
            st_d.rx  = '0;
            st_d.cnt = '0;
        end else if (active) begin
            st_d.rx  = rx_nxt;
            st_d.cnt = cnt_nxt;
            if (sck_fall_i) begin
                // refill from the newest received bit so the receive
                // stream follows the transmit byte out with a delay of DATA_W
                st_d.tx = {st_q.tx[DATA_W-2:0], st_q.rx[0]};
            end
            if (sel_rise_i && (cnt_nxt != '0)) begin
                st_d.vld = 1'b1;
                st_d.out = rx_nxt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdo_o      = st_q.tx[DATA_W-1];
    assign rx_byte_o  = st_q.out;
    assign rx_valid_o = st_q.vld;

    assert_msb_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_fall_i |=> (sdo_o == $past(tx_byte_i[DATA_W-1])));

    assert_sdo_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sck_fall_i && !sel_fall_i) |=> $stable(sdo_o));

    assert_idle_rx_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_prev_i && !sel_fall_i) |=> ($stable(st_q.rx) && !rx_valid_o));

    assert_valid_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> $past(sel_rise_i));

    assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

    assert_byte_with_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_byte_o) |-> rx_valid_o);
endmodule

// File: rtl/quad_wire_slave.sv
`timescale 1ns/1ps
module quad_wire_slave #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_i,
    input  logic              sel_n_i,
    input  logic              sdi_i,
    output logic              sdo_o,
    input  logic [DATA_W-1:0] tx_byte_i,
    output logic [DATA_W-1:0] rx_byte_o,
    output logic              rx_valid_o
);
    import qws_pkg::*;

    logic [NUM_SIG-1:0] pins;
    logic [NUM_SIG-1:0] lvl, prev, rise, fall;

    always_comb begin
        pins          = '0;
        pins[SIG_SCK] = sck_i;
        pins[SIG_SEL] = sel_n_i;
        pins[SIG_SDI] = sdi_i;
    end

    qws_edge_sync #(
        .WIDTH     (NUM_SIG),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (SIG_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pins),
        .lvl_o   (lvl),
        .prev_o  (prev),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    qws_shift_core #(
        .DATA_W (DATA_W)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_rise_i (rise[SIG_SCK]),
        .sck_fall_i (fall[SIG_SCK]),
        .sel_fall_i (fall[SIG_SEL]),
        .sel_rise_i (rise[SIG_SEL]),
        .sel_prev_i (prev[SIG_SEL]),
        .sdi_i      (lvl[SIG_SDI]),
        .tx_byte_i  (tx_byte_i),
        .sdo_o      (sdo_o),
        .rx_byte_o  (rx_byte_o),
        .rx_valid_o (rx_valid_o)
    );
endmodule

// File: tb/quad_wire_slave_tb.sv
`timescale 1ns/1ps
module quad_wire_slave_tb;
    localparam time TCLK = 4ns;
    localparam time H    = 40ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0, sel_n = 1'b1, sdi = 1'b0;
    logic       sdo;
    logic [7:0] tx_byte = 8'h00;
    logic [7:0] rx_byte;
    logic       rx_valid;

    int checks = 0, failures = 0;
    int pulses = 0, hi_cycles = 0;
    logic       vld_prev = 1'b0;
    logic [7:0] last_rx = 8'h00;
    logic       obs [32];
    bit         done = 0;

    // fields: tx byte [47:40], clock count [39:32], data-in pattern [31:0] (MSB sent first)
    localparam logic [47:0] VEC [6] = '{
        {8'hA5, 8'd8,  32'h3C00_0000},
        {8'h5A, 8'd8,  32'hC300_0000},
        {8'hF0, 8'd3,  32'hA000_0000},
        {8'h81, 8'd1,  32'h8000_0000},
        {8'h6E, 8'd12, 32'hB4D0_0000},
        {8'h33, 8'd20, 32'h9ABC_DE00}
    };

    quad_wire_slave u_dut (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .sel_n_i(sel_n), .sdi_i(sdi),
        .sdo_o(sdo), .tx_byte_i(tx_byte), .rx_byte_o(rx_byte), .rx_valid_o(rx_valid)
    );

    always #(TCLK/2) clk = ~clk;

    always @(negedge clk) begin
        if (rx_valid) begin
            hi_cycles++;
            if (!vld_prev) begin pulses++; last_rx = rx_byte; end
        end
        vld_prev = rx_valid;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rx(input int n, input logic [31:0] pat);
        logic [7:0] r = 8'h00;
        for (int i = 0; i < n; i++) r = {r[6:0], pat[31-i]};
        return r;
    endfunction

    task automatic burst(input logic [7:0] tx, input int n, input logic [31:0] pat,
                         input bit merge_last, input bit chg);
        tx_byte = tx;
        sel_n = 1'b0;
        #H;
        for (int i = 0; i < n; i++) begin
            sdi = pat[31-i];
            #(H/2);
            obs[i] = sdo;
            #(H/2);
            if (chg && i == 2) tx_byte = ~tx;
            if (merge_last && i == n-1) begin
                sck = 1'b1; sel_n = 1'b1; #H; sck = 1'b0;
            end else begin
                sck = 1'b1; #H; sck = 1'b0;
            end
        end
        #H;
        sel_n = 1'b1;
        #H; #H;
    endtask

    task automatic check_sdo(input logic [7:0] tx, input int n, input logic [31:0] pat);
        for (int i = 0; i < n; i++) begin
            logic e;
            e = (i < 8) ? tx[7-i] : pat[31-(i-8)];
            if (i == 0)     chk(obs[i] == e, "R3 first bit", 32'(obs[i]), 32'(e));
            else if (i < 8) chk(obs[i] == e, "R4 shift out", 32'(obs[i]), 32'(e));
            else            chk(obs[i] == e, "R5 echo", 32'(obs[i]), 32'(e));
        end
    endtask

    initial begin
        #(200000 * TCLK);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int p0;
        logic [7:0] s_rx;
        logic       s_sdo;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(sdo == 1'b0, "R1 sdo", 32'(sdo), 0);
        chk(rx_valid == 1'b0, "R1 valid", 32'(rx_valid), 0);
        chk(rx_byte == 8'h00, "R1 byte", 32'(rx_byte), 0);

        // vector table: R2 (8 clocks), R6 (short), R7 (long), R3/R4/R5 on sdo
        for (int v = 0; v < 6; v++) begin
            logic [7:0] tx;
            int n;
            logic [31:0] pat;
            tx = VEC[v][47:40]; n = int'(VEC[v][39:32]); pat = VEC[v][31:0];
            p0 = pulses;
            burst(tx, n, pat, 0, 0);
            check_sdo(tx, n, pat);
            if (n == 8)     chk(last_rx == exp_rx(n, pat), "R2 byte", 32'(last_rx), 32'(exp_rx(n, pat)));
            else if (n < 8) chk(last_rx == exp_rx(n, pat), "R6 short", 32'(last_rx), 32'(exp_rx(n, pat)));
            else            chk(last_rx == exp_rx(n, pat), "R7 long", 32'(last_rx), 32'(exp_rx(n, pat)));
            chk(pulses == p0 + 1, "R8 one pulse", 32'(pulses - p0), 1);
        end

        // R8 zero-clock burst delivers nothing
        p0 = pulses;
        burst(8'h77, 0, 32'h0, 0, 0);
        chk(pulses == p0, "R8 zero clocks", 32'(pulses - p0), 0);

        // R3 transmit byte changed mid-burst is ignored
        burst(8'hC6, 8, 32'h1100_0000, 0, 1);
        check_sdo(8'hC6, 8, 32'h1100_0000);
        tx_byte = 8'h00;

        // R9 clock and data activity while deselected
        p0 = pulses; s_rx = rx_byte; s_sdo = sdo;
        for (int k = 0; k < 6; k++) begin
            sdi = k[0]; sck = 1'b1; #H; sck = 1'b0; #H;
        end
        chk(pulses == p0, "R9 no pulse", 32'(pulses - p0), 0);
        chk(rx_byte == s_rx, "R9 byte held", 32'(rx_byte), 32'(s_rx));
        chk(sdo == s_sdo, "R9 sdo held", 32'(sdo), 32'(s_sdo));

        // R10 last clock rise coincides with select rise
        p0 = pulses;
        burst(8'h96, 8, 32'h5B00_0000, 1, 0);
        chk(last_rx == 8'h5B, "R10 merged edge", 32'(last_rx), 32'h5B);
        chk(pulses == p0 + 1, "R10 one pulse", 32'(pulses - p0), 1);

        // R8 every pulse lasted one cycle
        chk(hi_cycles == pulses, "R8 pulse width", 32'(hi_cycles), 32'(pulses));

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule